// File: doc/BRIEF.md
# Writeback Port Arbiter with Decode Hazard Stall

This block shares a single register-file write port among five result producers: a single-cycle integer unit, the integer and floating-point result paths of a shared multiplier, a floating-point adder and a load unit. In every cycle at most one of them is granted the port. The grant follows a fixed ranking based on the kind of unit and how early its result is known. It does not depend on the age of the instruction or on any rotation. A unit that loses keeps its request, tag and data on its inputs and is granted in a later cycle, once no higher-ranked unit is asking.

The block also tracks outstanding results per architectural register. When an instruction issues, the bit for its destination is marked pending. The bit is cleared when that register's writeback is granted. If any valid source operand in decode names a pending register, or names the register written back in the previous cycle, the decode stage is stalled. A consumer therefore goes ahead one clock after the writeback, not in the same clock.

Top module: `wb_port_arbiter`

## Requirements
- R1: At most one grant bit is high in any cycle, and a grant bit is high only if that unit's request is high.
- R2: Request index 0 (single-cycle integer unit) is granted whenever it requests, whatever the other requests.
- R3: Request index 4 (load unit) is granted only when indices 0 to 3 are all idle.
- R4: Among the middle units the ranking is index 1 (integer multiply) over index 2 (floating-point multiply) over index 3 (floating-point add).
- R5: A request that loses and stays asserted is granted in the first cycle in which no higher-ranked request is present.
- R6: The write enable is high exactly when a grant is given, and the write tag and data then equal the granted unit's tag and data. With no request, the write enable is low.
- R7: An issue (iss_vld high) marks its destination register pending at the next clock edge. A valid decode source that names a pending register raises stall.
- R8: A granted writeback clears the register's pending bit at the clock edge. In the following cycle a valid source naming that register still stalls, and from the cycle after that it does not.
- R9: If an issue and a granted writeback name the same register in the same cycle, the register stays pending.
- R10: A decode source whose valid bit is low never causes a stall.
- R11: After reset no register is pending and stall is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUNIT | Result-ready request per unit, index = rank (0 highest) |
| req_tag | input | NUNIT*TAG_W | Destination register per unit, unit k in slice k |
| req_data | input | NUNIT*DATA_W | Result data per unit, unit k in slice k |
| iss_vld | input | 1 | An instruction issues this cycle |
| iss_tag | input | TAG_W | Destination register of the issuing instruction |
| src_vld | input | NSRC | Decode source operand valid |
| src_tag | input | NSRC*TAG_W | Decode source registers, source k in slice k |
| gnt | output | NUNIT | One-hot grant |
| wr_en | output | 1 | Register-file write enable |
| wr_tag | output | TAG_W | Register-file write address |
| wr_data | output | DATA_W | Register-file write data |
| stall | output | 1 | Decode stall |

## Verification
The bench uses the default parameters: five units, 32 registers, 32-bit data and two decode sources. With five units, all 32 request patterns are legal, so the vector table can cover every rank pairing, including the multiplier's internal integer-over-float choice and the load unit being blocked. With two sources, the bench can show that a hazard on the second source stalls decode and that a source marked invalid is ignored. With 32 registers, a set-wins collision on one register can run alongside an independent hazard sequence on another register.

// File: rtl/wb_pkg.sv
package wb_pkg;
  // Request index doubles as rank: lower index wins.
  typedef enum int unsigned {
    U_ALU  = 0,
    U_IMUL = 1,
    U_FMUL = 2,
    U_FADD = 3,
    U_LOAD = 4
  } wb_unit_e;

  localparam int unsigned WB_NUNIT = 5;
endpackage

// File: rtl/wb_prio_sel.sv
module wb_prio_sel #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  // taken[i]: some index below i is requesting
  logic [N:0] taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_rank
    assign gnt[i]     = req[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req[i];
  end
endmodule

// File: rtl/wb_scoreboard.sv
module wb_scoreboard #(
  parameter int NREG  = 32,
  parameter int TAG_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_vld,
  input  logic [TAG_W-1:0] iss_tag,
  input  logic             wb_vld,
  input  logic [TAG_W-1:0] wb_tag,
  output logic [NREG-1:0]  pend,
  output logic             rec_vld,
  output logic [TAG_W-1:0] rec_tag
);
  logic [NREG-1:0]  pend_q, pend_d;
  logic             rec_vld_q, rec_vld_d;
  logic [TAG_W-1:0] rec_tag_q, rec_tag_d;
  logic             pend_en;

  assign pend_en = iss_vld | wb_vld;

  always_comb begin
    pend_d = pend_q;
    if (wb_vld)  pend_d[wb_tag]  = 1'b0;
    if (iss_vld) pend_d[iss_tag] = 1'b1;  // set wins over clear
    rec_vld_d = wb_vld;
    rec_tag_d = wb_vld ? wb_tag : rec_tag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      rec_vld_q <= 1'b0;
      rec_tag_q <= '0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      rec_vld_q <= rec_vld_d;
      if (wb_vld)  rec_tag_q <= rec_tag_d;
    end
  end

  assign pend    = pend_q;
  assign rec_vld = rec_vld_q;
  assign rec_tag = rec_tag_q;
endmodule

// File: rtl/wb_hazard.sv
module wb_hazard #(
  parameter int NREG  = 32,
  parameter int NSRC  = 2,
  parameter int TAG_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]       pend,
  input  logic                  rec_vld,
  input  logic [TAG_W-1:0]      rec_tag,
  input  logic [NSRC-1:0]       src_vld,
  input  logic [NSRC*TAG_W-1:0] src_tag,
  output logic                  stall
);
  logic [NSRC-1:0] hit;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [TAG_W-1:0] t;
    assign t      = src_tag[s*TAG_W +: TAG_W];
    assign hit[s] = src_vld[s] & (pend[t] | (rec_vld & (rec_tag == t)));
  end

  assign stall = |hit;
endmodule

// File: rtl/wb_port_arbiter.sv
module wb_port_arbiter #(
  parameter int NUNIT  = wb_pkg::WB_NUNIT,
  parameter int NREG   = 32,
  parameter int DATA_W = 32,
  parameter int NSRC   = 2,
  localparam int TAG_W = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUNIT-1:0]        req,
  input  logic [NUNIT*TAG_W-1:0]  req_tag,
  input  logic [NUNIT*DATA_W-1:0] req_data,
  input  logic                    iss_vld,
  input  logic [TAG_W-1:0]        iss_tag,
  input  logic [NSRC-1:0]         src_vld,
  input  logic [NSRC*TAG_W-1:0]   src_tag,
  output logic [NUNIT-1:0]        gnt,
  output logic                    wr_en,
  output logic [TAG_W-1:0]        wr_tag,
  output logic [DATA_W-1:0]       wr_data,
  output logic                    stall
);
  logic [NREG-1:0]  pend;
  logic             rec_vld;
  logic [TAG_W-1:0] rec_tag;

  wb_prio_sel #(.N(NUNIT)) u_sel (
    .req (req),
    .gnt (gnt)
  );

  // One-hot AND-OR write mux
  always_comb begin
    wr_en   = |gnt;
    wr_tag  = '0;
    wr_data = '0;
    for (int u = 0; u < NUNIT; u++) begin
      wr_tag  = wr_tag  | ({TAG_W{gnt[u]}}  & req_tag[u*TAG_W +: TAG_W]);
      wr_data = wr_data | ({DATA_W{gnt[u]}} & req_data[u*DATA_W +: DATA_W]);
    end
  end

  wb_scoreboard #(.NREG(NREG), .TAG_W(TAG_W)) u_sb (
    .clk     (clk),
    .rst_n   (rst_n),
    .iss_vld (iss_vld),
    .iss_tag (iss_tag),
    .wb_vld  (wr_en),
    .wb_tag  (wr_tag),
    .pend    (pend),
    .rec_vld (rec_vld),
    .rec_tag (rec_tag)
  );

  wb_hazard #(.NREG(NREG), .NSRC(NSRC), .TAG_W(TAG_W)) u_haz (
    .pend    (pend),
    .rec_vld (rec_vld),
    .rec_tag (rec_tag),
    .src_vld (src_vld),
    .src_tag (src_tag),
    .stall   (stall)
  );
endmodule

// File: rtl/wb_port_arbiter_chk.sv
module wb_port_arbiter_chk #(
  parameter int NUNIT  = 5,
  parameter int NREG   = 32,
  parameter int DATA_W = 32,
  parameter int NSRC   = 2,
  localparam int TAG_W = $clog2(NREG)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUNIT-1:0]        req,
  input logic [NUNIT-1:0]        gnt,
  input logic                    wr_en,
  input logic [TAG_W-1:0]        wr_tag,
  input logic [NSRC-1:0]         src_vld,
  input logic [NSRC*TAG_W-1:0]   src_tag,
  input logic                    stall
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r1_only_req: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  a_r2_alu_first: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |-> gnt[0]);
  a_r3_load_last: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[NUNIT-1] |-> (req[NUNIT-2:0] == '0));
  a_r4_imul_over_fmul: assert property (@(posedge clk) disable iff (!rst_n)
    req[1] |-> !gnt[2]);
  a_r6_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> !wr_en);
  a_r8_extra_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(wr_en) && src_vld[0]
     && (src_tag[TAG_W-1:0] == $past(wr_tag))) |-> stall);
  a_r10_invalid_src: assert property (@(posedge clk) disable iff (!rst_n)
    (src_vld == '0) |-> !stall);
endmodule

bind wb_port_arbiter wb_port_arbiter_chk #(
  .NUNIT(NUNIT), .NREG(NREG), .DATA_W(DATA_W), .NSRC(NSRC)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req     (req),
  .gnt     (gnt),
  .wr_en   (wr_en),
  .wr_tag  (wr_tag),
  .src_vld (src_vld),
  .src_tag (src_tag),
  .stall   (stall)
);

// File: tb/test_wb_port_arbiter.sv
`timescale 1ns/100ps
module test_wb_port_arbiter;
  localparam int NUNIT = 5, NREG = 32, DATA_W = 32, NSRC = 2;
  localparam int TAG_W = $clog2(NREG);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NUNIT-1:0]        req = '0;
  logic [NUNIT*TAG_W-1:0]  req_tag;
  logic [NUNIT*DATA_W-1:0] req_data;
  logic                    iss_vld = 1'b0;
  logic [TAG_W-1:0]        iss_tag = '0;
  logic [NSRC-1:0]         src_vld = '0;
  logic [NSRC*TAG_W-1:0]   src_tag = '0;
  logic [NUNIT-1:0]        gnt;
  logic                    wr_en, stall;
  logic [TAG_W-1:0]        wr_tag;
  logic [DATA_W-1:0]       wr_data;

  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  wb_port_arbiter #(.NUNIT(NUNIT), .NREG(NREG), .DATA_W(DATA_W), .NSRC(NSRC)) i_wb_port_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .req_tag(req_tag), .req_data(req_data),
    .iss_vld(iss_vld), .iss_tag(iss_tag), .src_vld(src_vld), .src_tag(src_tag),
    .gnt(gnt), .wr_en(wr_en), .wr_tag(wr_tag), .wr_data(wr_data), .stall(stall)
  );

  function automatic logic [TAG_W-1:0] utag(int u);
    return TAG_W'(u * 3 + 2);
  endfunction
  function automatic logic [DATA_W-1:0] udata(int u);
    return 32'hD000_0000 + DATA_W'(u);
  endfunction

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // {req, expected gnt}
  localparam logic [9:0] VEC [10] = '{
    {5'b00000, 5'b00000},
    {5'b11111, 5'b00001},
    {5'b11110, 5'b00010},
    {5'b00110, 5'b00010},
    {5'b01100, 5'b00100},
    {5'b11000, 5'b01000},
    {5'b10000, 5'b10000},
    {5'b10101, 5'b00001},
    {5'b11100, 5'b00100},
    {5'b10010, 5'b00010}
  };

  initial begin
    #100000;
    errs++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int u = 0; u < NUNIT; u++) begin
      req_tag[u*TAG_W +: TAG_W]    = utag(u);
      req_data[u*DATA_W +: DATA_W] = udata(u);
    end
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R11 reset state
    src_vld = 2'b11; src_tag = {TAG_W'(7), TAG_W'(5)};
    #1;
    chk("R11 stall after reset", 64'(stall), 64'd0);
    chk("R6 idle write enable", 64'(wr_en), 64'd0);
    src_vld = '0;

    // Arbitration table: R1 R2 R3 R4 R6
    for (int v = 0; v < 10; v++) begin
      step();
      req = VEC[v][9:5];
      #1;
      chk("R1-R4 grant", 64'(gnt), 64'(VEC[v][4:0]));
      chk("R6 write enable", 64'(wr_en), 64'(VEC[v][4:0] != 0));
      for (int u = 0; u < NUNIT; u++) if (VEC[v][u]) begin
        chk("R6 write tag", 64'(wr_tag), 64'(utag(u)));
        chk("R6 write data", 64'(wr_data), 64'(udata(u)));
      end
    end

    // R5 loser retries: load held while ALU busy, then wins
    step(); req = 5'b10001; #1;
    chk("R5 load blocked", 64'(gnt), 64'b00001);
    step(); req = 5'b10000; #1;
    chk("R5 load granted after", 64'(gnt), 64'b10000);
    step(); req = '0;

    // R7 R8 scoreboard hazard on register 5 via source 1
    req_tag[3*TAG_W +: TAG_W] = TAG_W'(5);
    iss_vld = 1'b1; iss_tag = TAG_W'(5);
    src_vld = 2'b10; src_tag = {TAG_W'(5), TAG_W'(0)};
    #1;
    chk("R7 not pending before edge", 64'(stall), 64'd0);
    step(); iss_vld = 1'b0; #1;
    chk("R7 pending stalls", 64'(stall), 64'd1);
    step(); req = 5'b01000; #1;
    chk("R8 stall in writeback cycle", 64'(stall), 64'd1);
    chk("R6 fadd tag", 64'(wr_tag), 64'd5);
    step(); req = '0; #1;
    chk("R8 extra clock stall", 64'(stall), 64'd1);
    step(); #1;
    chk("R8 released", 64'(stall), 64'd0);
    // R10 invalid source ignored while register pending
    iss_vld = 1'b1; iss_tag = TAG_W'(5);
    step(); iss_vld = 1'b0; src_vld = 2'b00; #1;
    chk("R10 invalid source", 64'(stall), 64'd0);
    src_vld = 2'b10; #1;
    chk("R7 pending again", 64'(stall), 64'd1);
    // clear register 5
    step(); req = 5'b01000;
    step(); req = '0; src_vld = '0;
    step();

    // R9 issue and writeback of register 9 same cycle
    req_tag[0 +: TAG_W] = TAG_W'(9);
    iss_vld = 1'b1; iss_tag = TAG_W'(9);
    step(); iss_vld = 1'b1; req = 5'b00001;
    step(); iss_vld = 1'b0; req = '0;
    src_vld = 2'b01; src_tag = {TAG_W'(0), TAG_W'(9)};
    step(); #1;
    chk("R9 set wins over clear", 64'(stall), 64'd1);
    src_vld = '0;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule